// File: doc/BRIEF.md
# Pilot Tone Identification Classifier

This block decides whether a broadcast sound carrier is mono, stereo or dual-language. Its input is the envelope of the identification pilot, already amplitude-demodulated and digitised. The pilot itself sits near 54.7 kHz and carries 50 % AM. The envelope therefore holds a low-frequency tone: about 117.4 Hz for stereo and about 274.1 Hz for two-language sound. The block removes the mean of the envelope, or takes a ready-made sign bit in its sign-input variant. It times the interval between successive upward zero crossings against a reference tick. It then sorts each interval into stereo, dual or neither.

A hysteresis stage turns these per-period verdicts into two status flags. A mode is declared only after a run of consecutive matching periods. The block falls back to mono only after a run of consecutive periods that fail to match. A period with no crossing at all ends at a timeout and counts as a failed match. While the enable input is low (muted, or the system is still in reset), the block clears its state and reports mono.

Top module: `pilot_id_classifier`

## Requirements
- R1: After reset all three outputs (`stereo_o`, `dual_o`, `valid_o`) are 0.
- R2: The flags encode the mode as stereo_o=1,dual_o=0 for stereo, stereo_o=0,dual_o=1 for dual sound, and 0,0 for mono. Both flags are never 1 together, and the block never moves from one tone mode to the other without passing through mono.
- R3: A period is the number of reference ticks between two successive rising crossings, where a rising crossing is a sample-strobe cycle whose mean-removed sample is non-negative after a negative one. The first crossing after enable or after a timeout only sets the start point.
- R4: A period counts as stereo when it lies in the inclusive range floor(0.95·Ps) to floor(1.05·Ps), with Ps = round(f_ref/117.4 Hz) ticks. The tolerance is a percentage parameter.
- R5: A period counts as dual when it lies in the inclusive range floor(0.95·Pd) to floor(1.05·Pd), with Pd = round(f_ref/274.1 Hz) ticks.
- R6: From mono, a mode is declared once CONFIRM (default 8) consecutive periods match the same tone. A non-matching period, or a period that matches the other tone, restarts the count.
- R7: From a tone mode, mono is restored after CONFIRM consecutive periods that do not match that mode. A matching period clears the miss count.
- R8: When no rising crossing occurs within the timeout (20 ms of reference ticks), the block issues one non-matching verdict and drops its start point. This repeats for every further timeout.
- R9: While `enable` is low, both flags read 0 from the next cycle on, envelope crossings are ignored, and all counts are cleared. Re-enabling starts from mono with no start point.
- R10: `valid_o` rises with the first period verdict after enable and falls in the cycle after `enable` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | High to classify; low while muted or in reset |
| smp_stb | input | 1 | One-cycle strobe marking a new envelope sample |
| smp_data | input | SAMPLE_W | Signed envelope sample; in the sign variant only its MSB (1 = negative) is used |
| stereo_o | output | 1 | Stereo transmission detected |
| dual_o | output | 1 | Dual-sound transmission detected |
| valid_o | output | 1 | At least one period verdict since enable |

## Verification
Two kinds of internal fault show up at the flags. A wrong period count or window bound moves a flag at a tone whose period sits exactly on a window edge. The sweep therefore drives each edge and its outer neighbour. A wrong run or miss counter moves a flag edge by one period. Each check samples one period before a flag is due to change and again at the period where it changes, so such a fault shows within one tone period. Faults in the clearing done by disable, or in the dropping of the start point at a timeout, shift the first declaration by one period after re-enable or after a silent gap.

// File: rtl/pid_pkg.sv
package pid_pkg;
   // Per-period verdict and, reused, the declared mode (NONE = mono)
   typedef enum logic [1:0] {
      TONE_NONE   = 2'd0,
      TONE_STEREO = 2'd1,
      TONE_DUAL   = 2'd2
   } tone_e;
endpackage

// File: rtl/pid_tick_gen.sv
module pid_tick_gen #(
   parameter int TICK_DIV = 5
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   generate
      if (TICK_DIV == 1) begin : g_direct
         assign tick_o = 1'b1;
      end else begin : g_div
         localparam int DW = $clog2(TICK_DIV);
         logic [DW-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          div_q <= '0;
            else if (div_q == DW'(TICK_DIV - 1)) div_q <= '0;
            else                                 div_q <= div_q + 1'b1;
         end
         assign tick_o = (div_q == DW'(TICK_DIV - 1));

         // R3
         tick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            div_q <= DW'(TICK_DIV - 1));
      end
   endgenerate
endmodule

// File: rtl/pid_crossing.sv
module pid_crossing #(
   parameter int USE_SAMPLES = 1,
   parameter int SAMPLE_W    = 12,
   parameter int MEAN_SHIFT  = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                enable,
   input  logic                stb_i,
   input  logic [SAMPLE_W-1:0] data_i,
   output logic                rise_o
);
   logic pos;
   logic prev_pos_q;

   generate
      if (USE_SAMPLES != 0) begin : g_mean
         localparam int AW = SAMPLE_W + MEAN_SHIFT;
         logic signed [AW-1:0] x_ext;
         logic signed [AW-1:0] acc_q;
         logic signed [AW-1:0] mean;

         assign x_ext = {{MEAN_SHIFT{data_i[SAMPLE_W-1]}}, data_i};
         assign mean  = acc_q >>> MEAN_SHIFT;
         assign pos   = (x_ext >= mean);

         // Leaky average: acc tracks mean << MEAN_SHIFT
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      acc_q <= '0;
            else if (!enable) acc_q <= '0;
            else if (stb_i)  acc_q <= acc_q + x_ext - mean;
         end
      end else begin : g_sign
         assign pos = ~data_i[SAMPLE_W-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       prev_pos_q <= 1'b1;
      else if (!enable) prev_pos_q <= 1'b1;
      else if (stb_i)   prev_pos_q <= pos;
   end

   assign rise_o = enable & stb_i & pos & ~prev_pos_q;
endmodule

// File: rtl/pid_period_meter.sv
module pid_period_meter
   import pid_pkg::*;
#(
   parameter int CW   = 18,
   parameter int S_LO = 80920,
   parameter int S_HI = 89437,
   parameter int D_LO = 34658,
   parameter int D_HI = 38307,
   parameter int TMO  = 200000
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  enable,
   input  logic  tick_i,
   input  logic  rise_i,
   output logic  vld_o,
   output tone_e kind_o
);
   logic [CW-1:0] cnt_q;
   logic          have_ref_q;
   tone_e         kind_q;
   logic          vld_q;
   tone_e         meas_kind;

   always_comb begin
      if (cnt_q >= CW'(S_LO) && cnt_q <= CW'(S_HI))      meas_kind = TONE_STEREO;
      else if (cnt_q >= CW'(D_LO) && cnt_q <= CW'(D_HI)) meas_kind = TONE_DUAL;
      else                                               meas_kind = TONE_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         have_ref_q <= 1'b0;
         vld_q      <= 1'b0;
         kind_q     <= TONE_NONE;
      end else if (!enable) begin
         cnt_q      <= '0;
         have_ref_q <= 1'b0;
         vld_q      <= 1'b0;
         kind_q     <= TONE_NONE;
      end else begin
         vld_q <= 1'b0;
         if (rise_i) begin
            if (have_ref_q) begin
               vld_q  <= 1'b1;
               kind_q <= meas_kind;
            end
            have_ref_q <= 1'b1;
            cnt_q      <= CW'(tick_i);
         end else if (cnt_q >= CW'(TMO)) begin
            vld_q      <= 1'b1;
            kind_q     <= TONE_NONE;
            have_ref_q <= 1'b0;
            cnt_q      <= '0;
         end else begin
            cnt_q <= cnt_q + CW'(tick_i);
         end
      end
   end

   assign vld_o  = vld_q;
   assign kind_o = kind_q;

   // R8
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(TMO));
   // R9
   no_verdict_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !vld_q);
   // R3
   verdict_needs_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && kind_q != TONE_NONE) |-> $past(have_ref_q));
endmodule

// File: rtl/pid_hysteresis.sv
module pid_hysteresis
   import pid_pkg::*;
#(
   parameter int CONFIRM = 8
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  enable,
   input  logic  vld_i,
   input  tone_e kind_i,
   output logic  stereo_o,
   output logic  dual_o,
   output logic  valid_o
);
   localparam int RW = $clog2(CONFIRM + 1);

   tone_e         mode_q;
   tone_e         cand_q;
   logic [RW-1:0] run_q;
   logic          valid_q;
   logic [RW-1:0] nrun;

   always_comb begin
      if (mode_q == TONE_NONE) nrun = (kind_i == cand_q) ? run_q + 1'b1 : RW'(1);
      else                     nrun = run_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= TONE_NONE;
         cand_q  <= TONE_NONE;
         run_q   <= '0;
         valid_q <= 1'b0;
      end else if (!enable) begin
         mode_q  <= TONE_NONE;
         cand_q  <= TONE_NONE;
         run_q   <= '0;
         valid_q <= 1'b0;
      end else if (vld_i) begin
         valid_q <= 1'b1;
         if (mode_q == TONE_NONE) begin
            if (kind_i == TONE_NONE) begin
               run_q  <= '0;
               cand_q <= TONE_NONE;
            end else if (nrun == RW'(CONFIRM)) begin
               mode_q <= kind_i;
               run_q  <= '0;
               cand_q <= TONE_NONE;
            end else begin
               run_q  <= nrun;
               cand_q <= kind_i;
            end
         end else if (kind_i == mode_q) begin
            run_q <= '0;
         end else if (nrun == RW'(CONFIRM)) begin
            mode_q <= TONE_NONE;
            run_q  <= '0;
            cand_q <= TONE_NONE;
         end else begin
            run_q <= nrun;
         end
      end
   end

   assign stereo_o = (mode_q == TONE_STEREO);
   assign dual_o   = (mode_q == TONE_DUAL);
   assign valid_o  = valid_q;

   // R2
   no_direct_sd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stereo_o |=> !dual_o);
   // R2
   no_direct_ds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dual_o |=> !stereo_o);
   // R6
   stereo_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stereo_o) |-> $past(vld_i && kind_i == TONE_STEREO));
   // R6
   dual_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dual_o) |-> $past(vld_i && kind_i == TONE_DUAL));
   // R9
   off_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!stereo_o && !dual_o && !valid_o));
   // R10
   valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && enable) |=> valid_o);
   // R6
   run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_q < RW'(CONFIRM));
endmodule

// File: rtl/pilot_id_classifier.sv
module pilot_id_classifier
   import pid_pkg::*;
#(
   parameter int USE_SAMPLES = 1,
   parameter int SAMPLE_W    = 12,
   parameter int MEAN_SHIFT  = 8,
   parameter int REF_HZ      = 10_000_000,
   parameter int TICK_DIV    = 5,
   parameter int STEREO_CHZ  = 11740,
   parameter int DUAL_CHZ    = 27410,
   parameter int TOL_PCT     = 5,
   parameter int CONFIRM     = 8,
   parameter int TIMEOUT_MS  = 20
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                enable,
   input  logic                smp_stb,
   input  logic [SAMPLE_W-1:0] smp_data,
   output logic                stereo_o,
   output logic                dual_o,
   output logic                valid_o
);
   localparam int S_P  = (REF_HZ * 100 + STEREO_CHZ / 2) / STEREO_CHZ;
   localparam int D_P  = (REF_HZ * 100 + DUAL_CHZ / 2) / DUAL_CHZ;
   localparam int S_LO = S_P * (100 - TOL_PCT) / 100;
   localparam int S_HI = S_P * (100 + TOL_PCT) / 100;
   localparam int D_LO = D_P * (100 - TOL_PCT) / 100;
   localparam int D_HI = D_P * (100 + TOL_PCT) / 100;
   localparam int TMO  = (REF_HZ * TIMEOUT_MS) / 1000;
   localparam int CW   = $clog2(TMO + 1);

   generate
      if (TOL_PCT < 0 || TOL_PCT > 30) begin : g_bad_tol
         $error("TOL_PCT out of range");
      end
      if (CONFIRM < 1) begin : g_bad_confirm
         $error("CONFIRM must be at least 1");
      end
      if (D_HI >= S_LO) begin : g_bad_overlap
         $error("stereo and dual windows overlap");
      end
      if (TMO <= S_HI) begin : g_bad_tmo
         $error("timeout shorter than stereo window");
      end
      if (TICK_DIV < 1 || SAMPLE_W < 1) begin : g_bad_div
         $error("TICK_DIV and SAMPLE_W must be positive");
      end
   endgenerate

   logic  tick;
   logic  rise;
   logic  vld;
   tone_e kind;

   pid_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick)
   );

   pid_crossing #(
      .USE_SAMPLES (USE_SAMPLES),
      .SAMPLE_W    (SAMPLE_W),
      .MEAN_SHIFT  (MEAN_SHIFT)
   ) u_cross (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (enable),
      .stb_i  (smp_stb),
      .data_i (smp_data),
      .rise_o (rise)
   );

   pid_period_meter #(
      .CW   (CW),
      .S_LO (S_LO),
      .S_HI (S_HI),
      .D_LO (D_LO),
      .D_HI (D_HI),
      .TMO  (TMO)
   ) u_meter (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (enable),
      .tick_i (tick),
      .rise_i (rise),
      .vld_o  (vld),
      .kind_o (kind)
   );

   pid_hysteresis #(.CONFIRM(CONFIRM)) u_hyst (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (enable),
      .vld_i    (vld),
      .kind_i   (kind),
      .stereo_o (stereo_o),
      .dual_o   (dual_o),
      .valid_o  (valid_o)
   );
endmodule

// File: tb/pilot_id_classifier_tb.sv
module pilot_id_classifier_tb;
   localparam int REF   = 23500;
   localparam int SCHZ  = 11740;
   localparam int DCHZ  = 27410;
   localparam int SP    = (REF * 100 + SCHZ / 2) / SCHZ;
   localparam int DP    = (REF * 100 + DCHZ / 2) / DCHZ;
   localparam int S_LO  = SP * 95 / 100;
   localparam int S_HI  = SP * 105 / 100;
   localparam int D_LO  = DP * 95 / 100;
   localparam int D_HI  = DP * 105 / 100;
   localparam int TMO   = REF * 20 / 1000;
   localparam int NP    = (S_LO + D_HI) / 2;   // matches neither window
   localparam int HI_W  = 30;                  // positive half width

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 1'b0;
   logic stb = 1'b1;
   logic [0:0] smp = 1'b0;
   logic st, ds, vl;
   int checks = 0;
   int fails = 0;

   always #10 clk = ~clk;

   pilot_id_classifier #(
      .USE_SAMPLES (0),
      .SAMPLE_W    (1),
      .MEAN_SHIFT  (1),
      .REF_HZ      (REF),
      .TICK_DIV    (1),
      .STEREO_CHZ  (SCHZ),
      .DUAL_CHZ    (DCHZ),
      .TOL_PCT     (5),
      .CONFIRM     (8),
      .TIMEOUT_MS  (20)
   ) u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (enable),
      .smp_stb  (stb),
      .smp_data (smp),
      .stereo_o (st),
      .dual_o   (ds),
      .valid_o  (vl)
   );

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // n periods of p cycles: negative part first, then a rising crossing
   task automatic train(input int p, input int n);
      for (int i = 0; i < n; i++) begin
         smp = 1'b1;
         cyc(p - HI_W);
         smp = 1'b0;
         cyc(HI_W);
      end
   endtask

   task automatic chk(input string req, input logic [2:0] expv);
      checks++;
      if ({st, ds, vl} !== expv) begin
         fails++;
         $display("FAIL %s: actual st/ds/valid=%b expected %b", req, {st, ds, vl}, expv);
      end
   endtask

   task automatic drop();
      train(NP, 8);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(2);
      chk("R1 reset state", 3'b000);

      enable = 1'b1;
      train(SP, 8);                         // first edge is start only: 7 verdicts
      chk("R6 seven stereo periods", 3'b001);
      chk("R10 valid after first verdict", 3'b001);
      train(SP, 1);
      chk("R4 eighth stereo period", 3'b101);
      train(NP, 7);
      chk("R7 seven misses hold", 3'b101);
      train(NP, 1);
      chk("R7 eighth miss drops", 3'b001);

      train(SP, 8);
      chk("R6 stereo after drop", 3'b101);
      train(NP, 5); train(SP, 1); train(NP, 7);
      chk("R7 match clears miss run", 3'b101);
      train(NP, 1);
      chk("R7 miss run completes", 3'b001);

      train(DP, 7);
      chk("R6 seven dual periods", 3'b001);
      train(DP, 1);
      chk("R5 eighth dual period", 3'b011);
      train(SP, 8);
      chk("R2 no direct dual to stereo", 3'b001);
      train(SP, 8);
      chk("R2 stereo after mono", 3'b101);

      drop();
      chk("R7 drop", 3'b001);
      train(SP, 4); train(DP, 4);
      chk("R6 other tone restarts run", 3'b001);
      train(DP, 4);
      chk("R6 dual after restart", 3'b011);
      drop();
      train(SP, 5); train(NP, 1); train(SP, 7);
      chk("R6 miss restarts run", 3'b001);
      train(SP, 1);
      chk("R6 run completes", 3'b101);

      for (int k = 0; k < 10; k++) begin
         int p;
         logic es, ed;
         case (k)
            0: p = S_LO - 1;  1: p = S_LO;  2: p = S_HI;  3: p = S_HI + 1;
            4: p = D_LO - 1;  5: p = D_LO;  6: p = D_HI;  7: p = D_HI + 1;
            8: p = SP;        default: p = DP;
         endcase
         es = (p >= S_LO) && (p <= S_HI);
         ed = (p >= D_LO) && (p <= D_HI);
         drop();
         train(p, 8);
         chk($sformatf("R4 R5 window sweep p=%0d", p), {es, ed, 1'b1});
      end

      drop();
      train(SP, 8);
      chk("R8 stereo before silence", 3'b101);
      cyc(TMO * 7 + 6 * 1 + 200 - HI_W);
      chk("R8 seven timeouts hold", 3'b101);
      cyc(TMO + 400);
      chk("R8 eighth timeout drops", 3'b001);
      train(SP, 8);
      chk("R8 start point dropped", 3'b001);
      train(SP, 1);
      chk("R8 stereo after silence", 3'b101);

      enable = 1'b0;
      cyc(1);
      chk("R9 R10 disable clears", 3'b000);
      train(SP, 9);
      chk("R9 crossings ignored while off", 3'b000);
      enable = 1'b1;
      cyc(2);
      chk("R10 no valid before verdict", 3'b000);
      train(SP, 8);
      chk("R9 state cleared on re-enable", 3'b001);
      train(SP, 1);
      chk("R9 stereo after re-enable", 3'b101);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule